// File: doc/BRIEF.md
# Single-Channel DMA Sequencer with Configuration Check

This block is one DMA channel. It copies a block of bytes from a source address to a destination address over a simple single-beat memory bus: one read, then one write, repeated until the byte count reaches zero. Software programs the source, destination, byte count and control word through a small register port. It then starts the channel in one of two ways: by setting a start bit, or by enabling the external request line and pulsing that line.

Before any bus access, the channel checks that the configured transfer sizes match the alignment of both addresses and the byte count. A bad setup causes no bus traffic; the channel only sets an error flag. A status word reports pending request, busy, done and configuration error. An interrupt is raised on normal completion or on a configuration error, and a programmable vector is returned on an interrupt acknowledge. Writing one to the done bit clears all latched status and the interrupt.

Top module: `dma_chan`

## Requirements
- R1: After reset the status word (address 4) reads 0, the vector register (address 5) reads 0x0F, and `irq`, `mem_req` and `iack_vec` are 0.
- R2: A transfer starts when control bit 0 (start) is written as 1, or when control bit 1 (external enable) is 1 and `ext_req` is sampled high. `ext_req` has no effect while external enable is 0.
- R3: The start bit reads back as 0 once the channel begins its first bus access, and it stays 0 after the transfer.
- R4: Size codes (control bits 6:5 for the source, 8:7 for the destination) are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes and 11 = reserved. A reserved code, a source or destination address not aligned to its own size, a zero count, or a count that is not a multiple of the step size leads to no bus access. Instead, status bit 3 (configuration error) is set, and `irq` is raised if control bit 2 (interrupt enable) is 1.
- R5: Each step reads one beat from the source and writes that data as one beat to the destination. The beat width is the larger of the two sizes, and `mem_size` carries its code. A transfer of N bytes takes exactly 2·N/step beats.
- R6: After each step, the count (address 2) falls by the step size. The source address (address 0) rises by the source size if control bit 3 is 1. The destination address (address 1) rises by the destination size if control bit 4 is 1.
- R7: Status bit 2 (request) is 1 from the cycle after a start is accepted until the channel is selected one cycle later. Status bit 1 (busy) is 1 from selection until the last write is acknowledged or the check fails.
- R8: When the count reaches zero after the final write acknowledge, status bit 0 (done) is set, busy drops, and `irq` is raised if interrupt enable is 1.
- R9: Writing status with bit 0 = 1 clears done, configuration error and `irq`. Writing bit 0 = 0 changes nothing.
- R10: The vector register is writable. One cycle after `iack` is high, `iack_vec` shows the vector; otherwise it shows 0.
- R11: While done is set, a start write or an external request is ignored: no bus access occurs and the start bit stays 0.
- R12: Once `mem_req` is raised, `mem_req`, `mem_we` and `mem_addr` hold until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 src, 1 dst, 2 count, 3 control, 4 status, 5 vector |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_addr` |
| ext_req | input | 1 | External transfer request |
| irq | output | 1 | Interrupt, level |
| iack | input | 1 | Interrupt acknowledge |
| iack_vec | output | VW | Vector returned on acknowledge |
| mem_req | output | 1 | Bus request, held until acknowledge |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Beat address |
| mem_size | output | 2 | Beat size code (R4 encoding) |
| mem_wdata | output | DW | Write data, little-endian in low bytes |
| mem_ack | input | 1 | Beat completion |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |

## Verification
The hardest case is the interaction of mixed source and destination sizes with independent increment bits. Here the step moves the larger size while each address advances by its own size, so reads and writes can overlap earlier beats. The bench sweeps every legal size pair, every address offset within a word and several increment and count mixes. It predicts the whole memory image by replaying the steps byte by byte. The one-cycle request window and the busy edge are reached by parking the register port on the status word right after the start write and sampling on consecutive cycles.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE
  } xfer_state_e;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_CTRL = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;
  localparam logic [2:0] REG_VEC  = 3'd5;

  // bytes moved by a size code; reserved gives 0
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_WORD: size_bytes = 3'd4;
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_chan_pkg::*;
(
  input  logic [1:0] src_lo,
  input  logic [1:0] dst_lo,
  input  logic [1:0] cnt_lo,
  input  logic       cnt_zero,
  input  logic [1:0] src_sz,
  input  logic [1:0] dst_sz,
  output logic       cfg_bad,
  output logic [1:0] step_code,
  output logic [2:0] step_bytes,
  output logic [2:0] src_bytes,
  output logic [2:0] dst_bytes
);

  function automatic logic misfit(input logic [1:0] lo, input logic [2:0] nb);
    misfit = (nb == 3'd2 && lo[0]) || (nb == 3'd4 && lo != 2'b00);
  endfunction

  always_comb begin
    src_bytes  = size_bytes(src_sz);
    dst_bytes  = size_bytes(dst_sz);
    step_bytes = (src_bytes > dst_bytes) ? src_bytes : dst_bytes;
    case (step_bytes)
      3'd4:    step_code = SZ_WORD;
      3'd2:    step_code = SZ_HALF;
      default: step_code = SZ_BYTE;
    endcase
    cfg_bad = (src_sz == SZ_RSVD) || (dst_sz == SZ_RSVD) ||
              misfit(src_lo, src_bytes) || misfit(dst_lo, dst_bytes) ||
              cnt_zero || misfit(cnt_lo, step_bytes);
  end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cfg_bad,
  input  logic [1:0]    step_code,
  input  logic [2:0]    step_bytes,
  input  logic [2:0]    src_bytes,
  input  logic [2:0]    dst_bytes,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  output logic [AW-1:0] src_nxt,
  output logic [AW-1:0] dst_nxt,
  output logic [CW-1:0] cnt_nxt,
  output logic          active,
  output logic          launch,
  output logic          cfg_fail,
  output logic          step_done,
  output logic          finish,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);

  xfer_state_e state;
  logic        last;

  always_comb begin
    src_nxt   = src + (src_inc ? AW'(src_bytes) : '0);
    dst_nxt   = dst + (dst_inc ? AW'(dst_bytes) : '0);
    cnt_nxt   = cnt - CW'(step_bytes);
    last      = (cnt == CW'(step_bytes));
    active    = (state != ST_IDLE);
    launch    = (state == ST_CHECK) && !cfg_bad;
    cfg_fail  = (state == ST_CHECK) && cfg_bad;
    step_done = (state == ST_WRITE) && mem_ack;
    finish    = step_done && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_CHECK;
        ST_CHECK: begin
          if (cfg_bad) state <= ST_IDLE;
          else begin
            state    <= ST_READ;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= src;
            mem_size <= step_code;
          end
        end
        ST_READ: if (mem_ack) begin
          state     <= ST_WRITE;
          mem_we    <= 1'b1;
          mem_addr  <= dst;
          mem_wdata <= mem_rdata;
        end
        ST_WRITE: if (mem_ack) begin
          mem_we <= 1'b0;
          if (last) begin
            state   <= ST_IDLE;
            mem_req <= 1'b0;
          end else begin
            state    <= ST_READ;
            mem_addr <= src_nxt;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R4
  cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_fail |=> (!mem_req && state == ST_IDLE));

  // R8
  last_beat_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> (!mem_req && !active));

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter int          CW      = 16,
  parameter int          VW      = 8,
  parameter logic [VW-1:0] VEC_RST = 8'h0F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ext_req,
  output logic          irq,
  input  logic          iack,
  output logic [VW-1:0] iack_vec,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);

  localparam int RW = 32;

  logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          go_q, ext_en_q, ie_q, sinc_q, dinc_q;
  logic [1:0]    ssz_q, dsz_q;
  logic          done_q, err_q, irq_q, ext_pend_q;
  logic [VW-1:0] vec_q;
  logic          pending, active, launch, cfg_fail, step_done, finish;
  logic          cfg_bad;
  logic [1:0]    step_code;
  logic [2:0]    step_bytes, src_bytes, dst_bytes;
  logic          wr_ctrl, wr_stat, stat_clr;
  logic [RW-1:0] stat_word, ctrl_word;

  assign pending  = go_q || ext_pend_q;
  assign wr_ctrl  = reg_we && reg_addr == REG_CTRL;
  assign wr_stat  = reg_we && reg_addr == REG_STAT;
  assign stat_clr = wr_stat && reg_wdata[0];
  assign irq      = irq_q;

  assign stat_word = {28'd0, err_q, pending && !active, active, done_q};
  assign ctrl_word = {23'd0, dsz_q, ssz_q, dinc_q, sinc_q, ie_q, ext_en_q, go_q};

  dma_cfg_check u_check (
    .src_lo    (src_q[1:0]),
    .dst_lo    (dst_q[1:0]),
    .cnt_lo    (cnt_q[1:0]),
    .cnt_zero  (cnt_q == '0),
    .src_sz    (ssz_q),
    .dst_sz    (dsz_q),
    .cfg_bad   (cfg_bad),
    .step_code (step_code),
    .step_bytes(step_bytes),
    .src_bytes (src_bytes),
    .dst_bytes (dst_bytes)
  );

  dma_xfer_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (pending && !done_q),
    .cfg_bad   (cfg_bad),
    .step_code (step_code),
    .step_bytes(step_bytes),
    .src_bytes (src_bytes),
    .dst_bytes (dst_bytes),
    .src_inc   (sinc_q),
    .dst_inc   (dinc_q),
    .src       (src_q),
    .dst       (dst_q),
    .cnt       (cnt_q),
    .src_nxt   (src_nxt),
    .dst_nxt   (dst_nxt),
    .cnt_nxt   (cnt_nxt),
    .active    (active),
    .launch    (launch),
    .cfg_fail  (cfg_fail),
    .step_done (step_done),
    .finish    (finish),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0;
      go_q <= 1'b0; ext_en_q <= 1'b0; ie_q <= 1'b0;
      sinc_q <= 1'b0; dinc_q <= 1'b0; ssz_q <= '0; dsz_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0; ext_pend_q <= 1'b0;
      vec_q <= VEC_RST; iack_vec <= '0; reg_rdata <= '0;
    end else begin
      if (step_done) begin
        src_q <= src_nxt; dst_q <= dst_nxt; cnt_q <= cnt_nxt;
      end else if (reg_we) begin
        if (reg_addr == REG_SRC) src_q <= reg_wdata[AW-1:0];
        if (reg_addr == REG_DST) dst_q <= reg_wdata[AW-1:0];
        if (reg_addr == REG_CNT) cnt_q <= reg_wdata[CW-1:0];
      end
      if (wr_ctrl) begin
        ext_en_q <= reg_wdata[1]; ie_q   <= reg_wdata[2];
        sinc_q   <= reg_wdata[3]; dinc_q <= reg_wdata[4];
        ssz_q    <= reg_wdata[6:5]; dsz_q <= reg_wdata[8:7];
      end
      if (reg_we && reg_addr == REG_VEC) vec_q <= reg_wdata[VW-1:0];
      // start request latching, cleared once the channel is selected
      if (launch || cfg_fail) go_q <= 1'b0;
      else if (wr_ctrl && !active && !done_q) go_q <= reg_wdata[0];
      if (launch || cfg_fail) ext_pend_q <= 1'b0;
      else if (ext_en_q && ext_req && !active && !done_q) ext_pend_q <= 1'b1;
      // latched status: a set in the same cycle wins over a clear
      if (finish) done_q <= 1'b1;
      else if (stat_clr) done_q <= 1'b0;
      if (cfg_fail) err_q <= 1'b1;
      else if (stat_clr) err_q <= 1'b0;
      if ((finish || cfg_fail) && ie_q) irq_q <= 1'b1;
      else if (stat_clr) irq_q <= 1'b0;
      iack_vec <= iack ? vec_q : '0;
      case (reg_addr)
        REG_SRC:  reg_rdata <= RW'(src_q);
        REG_DST:  reg_rdata <= RW'(dst_q);
        REG_CNT:  reg_rdata <= RW'(cnt_q);
        REG_CTRL: reg_rdata <= ctrl_word;
        REG_STAT: reg_rdata <= stat_word;
        REG_VEC:  reg_rdata <= RW'(vec_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !finish && !cfg_fail) |=> (!done_q && !err_q && !irq_q));

  // R11
  done_blocks_go_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && wr_ctrl) |=> !go_q);

  // R3
  go_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> !go_q);

  // R10
  iack_vec_chk: assert property (@(posedge clk) disable iff (rst)
    iack |=> (iack_vec == $past(vec_q)));

endmodule

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        ext_req = 1'b0;
  logic        irq;
  logic        iack = 1'b0;
  logic [7:0]  iack_vec;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;

  int nchk = 0, nfail = 0, beats = 0;
  bit finished = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] expm [256];

  always #2 clk = ~clk;

  dma_chan u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
    .irq(irq), .iack(iack), .iack_vec(iack_vec), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'b00) ? 4 : (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
  endfunction

  // bus memory model: ack one cycle after a request is seen
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mem_we) begin
          for (int i = 0; i < nbytes(mem_size); i++)
            mem[8'(mem_addr[7:0] + i)] = mem_wdata[8*i +: 8];
        end else begin
          mem_rdata = 32'd0;
          for (int i = 0; i < nbytes(mem_size); i++)
            mem_rdata[8*i +: 8] = mem[8'(mem_addr[7:0] + i)];
        end
        beats++;
        mem_ack = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      expm[i] = mem[i];
    end
  endtask

  task automatic wait_end(output logic [31:0] st);
    st = 32'd0;
    for (int k = 0; k < 400; k++) begin
      rd(3'd4, st);
      if (st[0] || st[3]) break;
    end
  endtask

  function automatic logic [31:0] ctrl_of(input int ss, input int ds, input bit si, input bit di,
                                          input bit ie, input bit ext, input bit go);
    return 32'(go) | (32'(ext) << 1) | (32'(ie) << 2) | (32'(si) << 3) | (32'(di) << 4) |
           (32'(ss) << 5) | (32'(ds) << 7);
  endfunction

  // program, start and check one transfer against the arithmetic model
  task automatic run(input int ss, input int ds, input int so, input int dof, input bit si,
                     input bit di, input bit ie, input int cnt, input bit use_ext);
    int sb, db, stp, s, d, nst;
    bit bad;
    logic [31:0] st, v;
    sb = nbytes(2'(ss)); db = nbytes(2'(ds));
    stp = (sb > db) ? sb : db;
    s = 'h10 + so; d = 'h80 + dof;
    bad = (ss == 3) || (ds == 3) || (sb > 0 && s % sb != 0) || (db > 0 && d % db != 0) ||
          cnt == 0 || (stp > 0 && cnt % stp != 0);
    init_mem();
    wr(3'd4, 32'd1);
    wr(3'd0, 32'(s)); wr(3'd1, 32'(d)); wr(3'd2, 32'(cnt));
    beats = 0;
    wr(3'd3, ctrl_of(ss, ds, si, di, ie, use_ext, !use_ext));
    if (use_ext) begin
      repeat (3) @(negedge clk);
      check(beats == 0 && !mem_req, "R2 ext enable waits for ext_req", 32'(beats), 32'd0);
      ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    end
    wait_end(st);
    nst = bad ? 0 : cnt / stp;
    if (!bad) begin
      for (int k = 0; k < nst; k++) begin
        logic [7:0] tmp [4];
        for (int b = 0; b < stp; b++) tmp[b] = expm[8'(s + b)];
        for (int b = 0; b < stp; b++) expm[8'(d + b)] = tmp[b];
        s += si ? sb : 0; d += di ? db : 0;
      end
    end
    check(st == (bad ? 32'h8 : 32'h1), bad ? "R4 error status" : "R8 done status", st, bad ? 32'h8 : 32'h1);
    check(irq == ie, bad ? "R4 irq on error" : "R8 irq on done", 32'(irq), 32'(ie));
    check(beats == 2 * nst, bad ? "R4 no bus access" : "R5 beat count", 32'(beats), 32'(2 * nst));
    if (!bad) begin
      int miss = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) miss++;
      check(miss == 0, "R5 memory image", 32'(miss), 32'd0);
      rd(3'd0, v); check(v == 32'(s), "R6 final src", v, 32'(s));
      rd(3'd1, v); check(v == 32'(d), "R6 final dst", v, 32'(d));
      rd(3'd2, v); check(v == 32'd0, "R6 final count", v, 32'd0);
    end
    rd(3'd3, v);
    check(v[0] == 1'b0, "R3 start bit reads 0", v, v & ~32'd1);
  endtask

  initial begin
    logic [31:0] v;
    int b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd4, v); check(v == 32'd0, "R1 status", v, 32'd0);
    rd(3'd5, v); check(v == 32'h0F, "R1 vector", v, 32'h0F);
    check(!irq && !mem_req && iack_vec == 8'd0, "R1 outputs", {irq, mem_req, iack_vec}, 32'd0);

    // R2 ext_req ignored while external enable is 0
    init_mem();
    wr(3'd0, 32'h10); wr(3'd1, 32'h80); wr(3'd2, 32'd4);
    wr(3'd3, ctrl_of(1, 1, 1, 1, 1, 0, 0));
    beats = 0;
    ext_req = 1'b1; repeat (2) @(negedge clk); ext_req = 1'b0;
    repeat (8) @(negedge clk);
    rd(3'd4, v);
    check(v == 32'd0 && beats == 0, "R2 ext_req ignored", v, 32'd0);

    // R2 external start path
    run(1, 0, 0, 0, 1, 1, 1, 8, 1);

    // R7 request then busy window, R3 start clears during transfer
    init_mem();
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h10); wr(3'd1, 32'h80); wr(3'd2, 32'd12);
    wr(3'd3, ctrl_of(1, 1, 1, 1, 1, 0, 1));
    reg_addr = 3'd4;
    @(negedge clk); check(reg_rdata == 32'h4, "R7 request bit", reg_rdata, 32'h4);
    @(negedge clk); check(reg_rdata == 32'h2, "R7 busy bit", reg_rdata, 32'h2);
    rd(3'd3, v); check(v[0] == 1'b0 && mem_req, "R3 start cleared in transfer", v, v & ~32'd1);
    wait_end(v); check(v == 32'h1, "R7 busy drops at done", v, 32'h1);

    // R11 start ignored while done is set
    b0 = beats;
    wr(3'd3, ctrl_of(1, 1, 1, 1, 1, 0, 1));
    ext_req = 1'b0;
    repeat (8) @(negedge clk);
    rd(3'd4, v); check(v == 32'h1 && beats == b0, "R11 status unchanged", v, 32'h1);
    rd(3'd3, v); check(v[0] == 1'b0, "R11 start stays 0", v, v & ~32'd1);

    // R9 write 0 no effect, write 1 clears all
    wr(3'd4, 32'd0);
    rd(3'd4, v); check(v == 32'h1 && irq, "R9 write 0 ignored", v, 32'h1);
    wr(3'd4, 32'd1);
    rd(3'd4, v); check(v == 32'h0 && !irq, "R9 clear done", v, 32'h0);
    run(3, 1, 0, 0, 1, 1, 1, 4, 0);
    wr(3'd4, 32'd1);
    rd(3'd4, v); check(v == 32'h0 && !irq, "R9 clear error", v, 32'h0);

    // R10 vector write and acknowledge
    wr(3'd5, 32'h5A);
    @(negedge clk); iack = 1'b1;
    @(negedge clk); iack = 1'b0;
    check(iack_vec == 8'h5A, "R10 iack returns vector", 32'(iack_vec), 32'h5A);
    @(negedge clk); check(iack_vec == 8'h00, "R10 idle vector 0", 32'(iack_vec), 32'h0);

    // R4 boundary counts and reserved codes
    run(0, 0, 0, 0, 1, 1, 0, 0, 0);
    run(0, 1, 0, 0, 1, 1, 1, 6, 0);
    run(1, 3, 0, 0, 1, 1, 0, 4, 0);

    // R5 R6 R4 sweep of sizes, offsets, increments and counts
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int so = 0; so < 4; so++)
          for (int dof = 0; dof < 4; dof++) begin
            int idx;
            idx = ((ss * 3 + ds) * 4 + so) * 4 + dof;
            run(ss, ds, so, dof, (idx % 3) != 0, (idx % 4) != 1, idx[1], (idx % 2) ? 8 : 12, 0);
          end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule